// File: doc/BRIEF.md
# PCIe Interrupt Status Aggregator

This block gathers the interrupt events a PCIe root-complex bridge receives and rolls them into one CPU interrupt line. Legacy INTx assert and deassert messages and accepted MSI writes set bits in a first-level status register. A separate auxiliary status register records power-state-change and flush events. Each status register has a mask register next to it.

MSI writes whose address equals a programmable 64-bit target are decoded. The low data bits select one of 32 vector status bits, the full message data is kept in a payload register, and the first-level MSI-pending bit is set. Any unmasked first-level bit sets a core summary bit in a host-level status register. The CPU interrupt output is the OR of the unmasked host-level bits.

Every status bit is sticky and cleared by writing 1. Software reaches all registers through a simple word-addressed write port and a combinational read port.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: After reset every status register and the payload read 0, the target address reads 0, the first-level mask reads 0x07FFFFFF, the host mask reads 0x00FFF0FB, the MSI mask reads 0xFFFFFFFF, and `cpu_irq` is 0.
- R2: A pulse on `intx_assert[n]` sets first-level bit 16+n. A pulse on `intx_deassert[n]` sets first-level bit 20+n, for n = 0..3.
- R3: An MSI write whose 64-bit address equals {target high, target low} does three things on the next edge: it sets MSI status bit data[4:0], loads the payload register with the data, and sets first-level bit 24. An MSI write to any other address changes none of these.
- R4: `pm_change_evt` sets auxiliary status bit 4 and `flush_evt` sets auxiliary status bit 5.
- R5: Writing a status register clears exactly the bits written as 1. Writing 0 leaves it unchanged.
- R6: When a new event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R7: Host status bit 16 is set on the clock edge after any first-level bit is 1 while its mask bit is 0. A first-level bit whose mask bit is 1 never sets it.
- R8: `cpu_irq` is 1 exactly when some host status bit is 1 with its host mask bit 0. Setting host mask bit 16 drops `cpu_irq` on the same edge.
- R9: Mask registers keep only valid bits (first level [26:0], auxiliary bits 4 and 5, host 0x00FFF0FB, MSI all 32). Reading an unmapped offset returns 0. The MSI mask is storage only and does not gate vector capture.
- R10: Register byte offsets: first-level status 0x00, mask 0x04; auxiliary status 0x08, mask 0x0C; target low 0x10, high 0x14; MSI status 0x18, mask 0x1C; payload 0x20; host status 0x24, mask 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| intx_assert | input | 4 | Per-line INTx assert message pulses |
| intx_deassert | input | 4 | Per-line INTx deassert message pulses |
| pm_change_evt | input | 1 | Power-state-change event pulse |
| flush_evt | input | 1 | Flush event pulse |
| msi_wr_vld | input | 1 | Inbound MSI write valid |
| msi_wr_addr | input | 64 | Inbound MSI write address |
| msi_wr_data | input | 32 | Inbound MSI write data |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The bench targets four cases. The first is an event and a clear hitting the same bit in one cycle: a design that let the clear win would lose an interrupt. The second is clearing the host summary while a first-level source is still unmasked: a wrong design would drop the summary while work is still pending. The third is the one-cycle latency from a first-level bit to `cpu_irq`: sampling one cycle too early or too late exposes a missing or extra register stage. The fourth is an MSI to a non-matching address: a careless comparator would capture a vector and overwrite the payload.

// File: rtl/pcie_irq_aggregator.sv
module pcie_irq_aggregator #(
  parameter int          ADDR_W        = 8,
  parameter int          DATA_W        = 32,
  parameter int          NUM_INTX      = 4,
  parameter int          MSI_VECS      = 32,
  parameter int          INTX_SET_LSB  = 16,
  parameter int          INTX_CLR_LSB  = 20,
  parameter int          MSI_PEND_BIT  = 24,
  parameter int          AUX_PM_BIT    = 4,
  parameter int          AUX_FLUSH_BIT = 5,
  parameter int          HOST_CORE_BIT = 16,
  parameter logic [31:0] L1_VALID      = 32'h07FF_FFFF,
  parameter logic [31:0] HOST_VALID    = 32'h00FF_F0FB,
  parameter logic [7:0]  OFF_L1_ST     = 8'h00,
  parameter logic [7:0]  OFF_L1_MSK    = 8'h04,
  parameter logic [7:0]  OFF_AUX_ST    = 8'h08,
  parameter logic [7:0]  OFF_AUX_MSK   = 8'h0C,
  parameter logic [7:0]  OFF_TGT_LO    = 8'h10,
  parameter logic [7:0]  OFF_TGT_HI    = 8'h14,
  parameter logic [7:0]  OFF_MSI_ST    = 8'h18,
  parameter logic [7:0]  OFF_MSI_MSK   = 8'h1C,
  parameter logic [7:0]  OFF_PAYLOAD   = 8'h20,
  parameter logic [7:0]  OFF_HOST_ST   = 8'h24,
  parameter logic [7:0]  OFF_HOST_MSK  = 8'h28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_INTX-1:0]   intx_assert,
  input  logic [NUM_INTX-1:0]   intx_deassert,
  input  logic                  pm_change_evt,
  input  logic                  flush_evt,
  input  logic                  msi_wr_vld,
  input  logic [2*DATA_W-1:0]   msi_wr_addr,
  input  logic [DATA_W-1:0]     msi_wr_data,
  output logic                  cpu_irq
);

  localparam int          VEC_W     = $clog2(MSI_VECS);
  localparam logic [DATA_W-1:0] L1_V   = DATA_W'(L1_VALID);
  localparam logic [DATA_W-1:0] HOST_V = DATA_W'(HOST_VALID);
  localparam logic [DATA_W-1:0] AUX_V  = (DATA_W'(1) << AUX_PM_BIT) | (DATA_W'(1) << AUX_FLUSH_BIT);

  logic [DATA_W-1:0]   l1_st, l1_msk, aux_st, aux_msk, host_st, host_msk;
  logic [DATA_W-1:0]   tgt_lo, tgt_hi, payload;
  logic [MSI_VECS-1:0] msi_st, msi_msk;
  logic [DATA_W-1:0]   l1_set, aux_set, host_set;
  logic [MSI_VECS-1:0] msi_set;
  logic                msi_hit;

  function automatic logic [DATA_W-1:0] w1c_next(input logic [DATA_W-1:0] cur, clr, set, valid);
    return ((cur & ~clr) | set) & valid;
  endfunction

  function automatic logic [DATA_W-1:0] clr_of(input logic we, input logic [ADDR_W-1:0] a,
                                               input logic [ADDR_W-1:0] off, input logic [DATA_W-1:0] d);
    return (we && a == off) ? d : '0;
  endfunction

  assign msi_hit = msi_wr_vld && (msi_wr_addr == {tgt_hi, tgt_lo});
  assign msi_set = msi_hit ? (MSI_VECS'(1) << msi_wr_data[VEC_W-1:0]) : '0;

  always_comb begin
    l1_set = '0;
    for (int n = 0; n < NUM_INTX; n++) begin
      l1_set[INTX_SET_LSB+n] = intx_assert[n];
      l1_set[INTX_CLR_LSB+n] = intx_deassert[n];
    end
    l1_set[MSI_PEND_BIT] = msi_hit;
  end

  always_comb begin
    aux_set = '0;
    aux_set[AUX_PM_BIT]    = pm_change_evt;
    aux_set[AUX_FLUSH_BIT] = flush_evt;
  end

  always_comb begin
    host_set = '0;
    host_set[HOST_CORE_BIT] = |(l1_st & ~l1_msk);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_st    <= '0;
      aux_st   <= '0;
      host_st  <= '0;
      msi_st   <= '0;
      l1_msk   <= L1_V;
      aux_msk  <= AUX_V;
      host_msk <= HOST_V;
      msi_msk  <= '1;
      tgt_lo   <= '0;
      tgt_hi   <= '0;
      payload  <= '0;
    end else begin
      l1_st   <= w1c_next(l1_st,   clr_of(reg_we, reg_addr, ADDR_W'(OFF_L1_ST),   reg_wdata), l1_set,   L1_V);
      aux_st  <= w1c_next(aux_st,  clr_of(reg_we, reg_addr, ADDR_W'(OFF_AUX_ST),  reg_wdata), aux_set,  AUX_V);
      host_st <= w1c_next(host_st, clr_of(reg_we, reg_addr, ADDR_W'(OFF_HOST_ST), reg_wdata), host_set, HOST_V);
      msi_st  <= (msi_st & ~MSI_VECS'(clr_of(reg_we, reg_addr, ADDR_W'(OFF_MSI_ST), reg_wdata))) | msi_set;
      if (msi_hit) payload <= msi_wr_data;
      if (reg_we) begin
        case (reg_addr)
          ADDR_W'(OFF_L1_MSK):   l1_msk   <= reg_wdata & L1_V;
          ADDR_W'(OFF_AUX_MSK):  aux_msk  <= reg_wdata & AUX_V;
          ADDR_W'(OFF_HOST_MSK): host_msk <= reg_wdata & HOST_V;
          ADDR_W'(OFF_MSI_MSK):  msi_msk  <= MSI_VECS'(reg_wdata);
          ADDR_W'(OFF_TGT_LO):   tgt_lo   <= reg_wdata;
          ADDR_W'(OFF_TGT_HI):   tgt_hi   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(OFF_L1_ST):    reg_rdata = l1_st;
      ADDR_W'(OFF_L1_MSK):   reg_rdata = l1_msk;
      ADDR_W'(OFF_AUX_ST):   reg_rdata = aux_st;
      ADDR_W'(OFF_AUX_MSK):  reg_rdata = aux_msk;
      ADDR_W'(OFF_TGT_LO):   reg_rdata = tgt_lo;
      ADDR_W'(OFF_TGT_HI):   reg_rdata = tgt_hi;
      ADDR_W'(OFF_MSI_ST):   reg_rdata = DATA_W'(msi_st);
      ADDR_W'(OFF_MSI_MSK):  reg_rdata = DATA_W'(msi_msk);
      ADDR_W'(OFF_PAYLOAD):  reg_rdata = payload;
      ADDR_W'(OFF_HOST_ST):  reg_rdata = host_st;
      ADDR_W'(OFF_HOST_MSK): reg_rdata = host_msk;
      default:               reg_rdata = '0;
    endcase
  end

  assign cpu_irq = |(host_st & ~host_msk);

  // Assertions
  for (genvar n = 0; n < NUM_INTX; n++) begin : g_intx_chk
    assert_intx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      intx_assert[n] |=> l1_st[INTX_SET_LSB+n]);
    assert_intx_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      intx_deassert[n] |=> l1_st[INTX_CLR_LSB+n]);
  end

  assert_msi_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_hit |=> l1_st[MSI_PEND_BIT] && payload == $past(msi_wr_data));

  assert_aux_pm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_change_evt |=> aux_st[AUX_PM_BIT]);

  assert_l1_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && intx_assert == '0 && intx_deassert == '0 && !msi_wr_vld) |=> $stable(l1_st));

  assert_rollup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(l1_st & ~l1_msk)) |=> host_st[HOST_CORE_BIT]);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> host_st[HOST_CORE_BIT] && !host_msk[HOST_CORE_BIT]);

endmodule

// File: tb/tb_pcie_irq_aggregator.sv
module tb_pcie_irq_aggregator;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [3:0]  intx_assert = 0, intx_deassert = 0;
  logic        pm_change_evt = 0, flush_evt = 0, msi_wr_vld = 0;
  logic [63:0] msi_wr_addr = 0;
  logic [31:0] msi_wr_data = 0;
  logic        cpu_irq;

  localparam logic [63:0] TGT = 64'h0000_0002_1000_0040;
  localparam logic [7:0] L1S = 8'h00, L1M = 8'h04, AXS = 8'h08, TLO = 8'h10, THI = 8'h14,
                         MSS = 8'h18, MSM = 8'h1C, PAY = 8'h20, HS = 8'h24, HM = 8'h28;
  localparam logic [1:0] OP_WR = 0, OP_RD = 1, OP_INTX = 2, OP_MSI = 3;
  localparam int NV = 25;
  // {op, addr, data, expected}
  localparam logic [73:0] VEC [NV] = '{
    {OP_RD,   L1M, 32'h0,          32'h07FF_FFFF},
    {OP_RD,   HM,  32'h0,          32'h00FF_F0FB},
    {OP_RD,   MSM, 32'h0,          32'hFFFF_FFFF},
    {OP_WR,   TLO, 32'h1000_0040,  32'h0},
    {OP_WR,   THI, 32'h0000_0002,  32'h0},
    {OP_RD,   TLO, 32'h0,          32'h1000_0040},
    {OP_INTX, L1S, 32'h01,         32'h0},
    {OP_RD,   L1S, 32'h0,          32'h0001_0000},
    {OP_RD,   HS,  32'h0,          32'h0},
    {OP_WR,   L1M, 32'hFFFF_FFFF,  32'h0},
    {OP_RD,   L1M, 32'h0,          32'h07FF_FFFF},
    {OP_WR,   L1M, 32'hFFFE_FFFF,  32'h0},
    {OP_RD,   HS,  32'h0,          32'h0001_0000},
    {OP_INTX, L1S, 32'h80,         32'h0},
    {OP_RD,   L1S, 32'h0,          32'h0081_0000},
    {OP_MSI,  L1S, 32'h0000_A505,  32'h0},
    {OP_RD,   MSS, 32'h0,          32'h0000_0020},
    {OP_RD,   PAY, 32'h0,          32'h0000_A505},
    {OP_RD,   L1S, 32'h0,          32'h0181_0000},
    {OP_WR,   L1S, 32'h0001_0000,  32'h0},
    {OP_RD,   L1S, 32'h0,          32'h0180_0000},
    {OP_WR,   HS,  32'h0001_0000,  32'h0},
    {OP_RD,   HS,  32'h0,          32'h0},
    {OP_WR,   MSS, 32'h0000_0020,  32'h0},
    {OP_RD,   MSS, 32'h0,          32'h0}
  };

  int checks = 0, fails = 0;

  pcie_irq_aggregator dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic intx(input logic [7:0] v);
    @(negedge clk); intx_assert = v[3:0]; intx_deassert = v[7:4];
    @(negedge clk); intx_assert = 0; intx_deassert = 0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); msi_wr_vld = 1; msi_wr_addr = a; msi_wr_data = d;
    @(negedge clk); msi_wr_vld = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", L1S, 32'h0);
    rd("R1", HS, 32'h0);
    rd("R1", PAY, 32'h0);
    rd("R1", THI, 32'h0);
    chk("R1", {31'b0, cpu_irq}, 32'h0);

    // vector table (R1 R2 R3 R5 R7 R9 R10)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        OP_WR:   wr(VEC[i][71:64], VEC[i][63:32]);
        OP_RD:   rd("R10/R2/R3/R5/R7 table", VEC[i][71:64], VEC[i][31:0]);
        OP_INTX: intx(VEC[i][39:32]);
        default: msi(TGT, VEC[i][63:32]);
      endcase
    end

    wr(L1S, 32'h07FF_FFFF);
    rd("R5", L1S, 32'h0);

    // R8 and R7 latency
    wr(HM, 32'hFFFE_FFFF);
    rd("R9", HM, 32'h00FE_F0FB);
    chk("R8", {31'b0, cpu_irq}, 32'h0);
    intx(8'h01);
    chk("R7 latency", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    chk("R8", {31'b0, cpu_irq}, 32'h1);
    wr(HM, 32'hFFFF_FFFF);
    chk("R8 host mask", {31'b0, cpu_irq}, 32'h0);
    wr(HM, 32'hFFFE_FFFF);
    chk("R8", {31'b0, cpu_irq}, 32'h1);

    // R6 event beats clear in the same cycle
    @(negedge clk); intx_assert = 4'h1; reg_we = 1; reg_addr = L1S; reg_wdata = 32'h0001_0000;
    @(negedge clk); intx_assert = 0; reg_we = 0; reg_wdata = 0;
    rd("R6", L1S, 32'h0001_0000);

    // R5 write of zero has no effect
    wr(L1S, 32'h0);
    rd("R5", L1S, 32'h0001_0000);

    // R5 full clear path
    wr(L1S, 32'h0001_0000);
    wr(HS, 32'h0001_0000);
    rd("R5", HS, 32'h0);
    chk("R8", {31'b0, cpu_irq}, 32'h0);

    // R6 host clear while unmasked source pending
    intx(8'h01);
    wr(HS, 32'h0001_0000);
    rd("R6 host", HS, 32'h0001_0000);
    wr(L1S, 32'h0001_0000);
    wr(HS, 32'h0001_0000);
    chk("R7", {31'b0, cpu_irq}, 32'h0);

    // R3 non-matching address ignored
    msi(64'h0000_0002_1000_0044, 32'h0000_0003);
    rd("R3 miss", MSS, 32'h0);
    rd("R3 miss", PAY, 32'h0000_A505);
    rd("R3 miss", L1S, 32'h0);

    // R3 top vector, R9 MSI mask does not gate
    msi(TGT, 32'h0000_001F);
    rd("R3", MSS, 32'h8000_0000);
    rd("R3", PAY, 32'h0000_001F);
    wr(MSM, 32'h0);
    rd("R9", MSM, 32'h0);

    // R4 auxiliary events
    @(negedge clk); pm_change_evt = 1;
    @(negedge clk); pm_change_evt = 0;
    rd("R4", AXS, 32'h0000_0010);
    @(negedge clk); flush_evt = 1;
    @(negedge clk); flush_evt = 0;
    rd("R4", AXS, 32'h0000_0030);
    wr(AXS, 32'h0000_0010);
    rd("R4 R5", AXS, 32'h0000_0020);

    // R9 unmapped offset
    rd("R9", 8'h3C, 32'h0);
    summary();
  end
endmodule